// File: doc/BRIEF.md
# SMBus Byte-Protocol Register Slave

This block is a slave-only SMBus target. It lets a host read and write a bank of 8-bit registers, one byte per transaction. Four transactions are recognised: Write Byte, Read Byte, Send Byte and Receive Byte. Every other framing is refused by withholding the acknowledge from the point where it stops matching one of those four. The block never drives SCL and never originates a START. It watches SCL and SDA as open-drain inputs and pulls SDA low through a single active-high output.

On its inside the block offers a plain register port. It provides an address, write data and a one-cycle write strobe. It also provides a one-cycle read strobe, and the register file answers that strobe with read data in the following clock cycle. A register pointer holds the last command byte. Writes go to the register that the command byte of the same transaction names. Reads come from the pointer. This lets the block sit in front of any register file. Both bus lines pass through a synchroniser clocked by the system clock, so the supported bus rates (10 kHz to 400 kHz) only need a system clock many times faster than SCL.

Top module: `smbusByteSlave`

## Requirements
- R1: While reset is held, sdaDriveLow, regWrEn and regRdEn are 0 and regAddr is 8'h00.
- R2: Bytes travel MSB first. In the address byte the 7-bit address sits in bits 7:1 and bit 0 is 1 for a read. If bits 7:1 differ from the SLAVE_ADDR parameter, that byte and every later byte before the next START get no ACK (SDA is not driven), no strobe fires, and regAddr keeps its value.
- R3: Write Byte (START, address with bit 0 = 0, command, data, STOP) gets an ACK (SDA low) on all three bytes. It produces exactly one regWrEn pulse, with regAddr equal to the command and regWrData equal to the data.
- R4: Send Byte (START, address write, command, STOP) gets an ACK on both bytes and loads the command into the pointer, so regAddr shows it. No write strobe fires.
- R5: Receive Byte (START, address with bit 0 = 1) gets an ACK on the address. It then issues one regRdEn pulse with regAddr equal to the pointer. It takes regRdData at the clock edge that ends the cycle after the pulse and shifts that byte out MSB first.
- R6: Read Byte (address write, command, repeated START, address read) returns the register that its command names.
- R7: Any byte that follows the data byte of a Write Byte gets no ACK and causes no further write.
- R8: A START or STOP in the middle of a transaction abandons it, so a partly received data byte is never written. SDA is released in the clock cycle after a START is recognised.
- R9: sdaDriveLow changes only while the synchronised SCL is low.
- R10: An ACK holds SDA low through the high phase of the ninth clock. SDA is released at the SCL fall that ends that clock, except when the first read bit follows.
- R11: regWrEn and regRdEn are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SMBus clock line level |
| sdaIn | input | 1 | SMBus data line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| regAddr | output | 8 | Register address (the pointer) |
| regWrData | output | 8 | Data for the register write |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdEn | output | 1 | One-cycle read strobe |
| regRdData | input | 8 | Register contents, valid the cycle after regRdEn |

## Verification
A wrong state in the control shows up at the bus within one bit time, as a missing ACK or a stray one, because every ACK decision is made at the SCL fall after the eighth bit. A wrong bit count or a wrong shift shows up as a corrupted read byte, or as a write strobe carrying the wrong address or data. Both can be seen the moment the transaction ends. Sweeps of all sixteen written addresses and of many non-matching addresses, together with partial bytes cut off by STOP or repeated START, expose a control that returns to the wrong state after an abandon.

// File: rtl/smbusSlvPkg.sv
package smbusSlvPkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RD_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_TX,
    ST_SKIP
  } slvState_t;

  // Bus events from the line synchroniser
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
  } busEvt_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic cntClr;
    logic bitTick;
    logic ptrLoad;
    logic wrStrobe;
    logic rdStrobe;
    logic ackDrive;
    logic sdaFree;
    logic txFirst;
    logic txNext;
  } dpCtrl_t;

endpackage

// File: rtl/smbusLineSync.sv
module smbusLineSync
  import smbusSlvPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output busEvt_t evt,
  output logic    sclLevel,
  output logic    sdaLevel
);

  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclChain[0] <= sclIn;
      sdaChain[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclChain[i] <= sclChain[i-1];
        sdaChain[i] <= sdaChain[i-1];
      end
      sclPrev <= sclChain[SYNC_STAGES-1];
      sdaPrev <= sdaChain[SYNC_STAGES-1];
    end
  end

  assign sclLevel = sclChain[SYNC_STAGES-1];
  assign sdaLevel = sdaChain[SYNC_STAGES-1];

  always_comb begin
    evt.sclRise   = sclLevel & ~sclPrev;
    evt.sclFall   = ~sclLevel & sclPrev;
    evt.startSeen = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
    evt.stopSeen  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;
  end

endmodule

// File: rtl/smbusSlvControl.sv
module smbusSlvControl
  import smbusSlvPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [CNT_W-1:0]  bitCnt,
  output dpCtrl_t           ctl
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  slvState_t state, stateNext;
  logic byteDone;
  logic bitRoom;

  assign byteDone = evt.sclFall && (bitCnt == FULL_CNT);
  assign bitRoom  = evt.sclRise && (bitCnt != FULL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    if (evt.stopSeen) begin
      stateNext   = ST_IDLE;
      ctl.sdaFree = 1'b1;
    end else if (evt.startSeen) begin
      stateNext   = ST_ADDR;
      ctl.cntClr  = 1'b1;
      ctl.sdaFree = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          ctl.bitTick = bitRoom;
          if (byteDone) begin
            if (rxByte[BYTE_W-1:1] == SLAVE_ADDR) begin
              ctl.ackDrive = 1'b1;
              if (rxByte[0]) begin
                ctl.rdStrobe = 1'b1;
                stateNext    = ST_RD_ACK;
              end else begin
                stateNext = ST_ADDR_ACK;
              end
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_CMD: begin
          ctl.bitTick = bitRoom;
          if (byteDone) begin
            ctl.ackDrive = 1'b1;
            ctl.ptrLoad  = 1'b1;
            stateNext    = ST_CMD_ACK;
          end
        end
        ST_DATA: begin
          ctl.bitTick = bitRoom;
          if (byteDone) begin
            ctl.ackDrive = 1'b1;
            ctl.wrStrobe = 1'b1;
            stateNext    = ST_DATA_ACK;
          end
        end
        ST_ADDR_ACK: begin
          if (evt.sclFall) begin
            ctl.sdaFree = 1'b1;
            ctl.cntClr  = 1'b1;
            stateNext   = ST_CMD;
          end
        end
        ST_CMD_ACK: begin
          if (evt.sclFall) begin
            ctl.sdaFree = 1'b1;
            ctl.cntClr  = 1'b1;
            stateNext   = ST_DATA;
          end
        end
        ST_DATA_ACK: begin
          if (evt.sclFall) begin
            ctl.sdaFree = 1'b1;
            stateNext   = ST_SKIP;
          end
        end
        ST_RD_ACK: begin
          if (evt.sclFall) begin
            ctl.txFirst = 1'b1;
            ctl.cntClr  = 1'b1;
            stateNext   = ST_TX;
          end
        end
        ST_TX: begin
          ctl.bitTick = bitRoom;
          if (evt.sclFall) begin
            if (bitCnt == FULL_CNT) begin
              ctl.sdaFree = 1'b1;
              stateNext   = ST_SKIP;
            end else begin
              ctl.txNext = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smbusSlvDatapath.sv
module smbusSlvDatapath
  import smbusSlvPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              sdaDriveLow
);

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] regPtr;
  logic              rdPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift     <= '0;
      txShift     <= '0;
      regPtr      <= '0;
      regWrData   <= '0;
      regWrEn     <= 1'b0;
      regRdEn     <= 1'b0;
      rdPend      <= 1'b0;
      bitCnt      <= '0;
      sdaDriveLow <= 1'b0;
    end else begin
      regWrEn <= ctl.wrStrobe;
      regRdEn <= ctl.rdStrobe;
      rdPend  <= regRdEn;

      if (ctl.cntClr) begin
        bitCnt <= '0;
      end else if (ctl.bitTick) begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= {rxShift[BYTE_W-2:0], sdaBit};
      end

      if (ctl.ptrLoad)  regPtr    <= rxShift;
      if (ctl.wrStrobe) regWrData <= rxShift;

      if (rdPend)          txShift <= regRdData;
      else if (ctl.txNext) txShift <= {txShift[BYTE_W-2:0], 1'b0};

      if (ctl.sdaFree)       sdaDriveLow <= 1'b0;
      else if (ctl.ackDrive) sdaDriveLow <= 1'b1;
      else if (ctl.txFirst)  sdaDriveLow <= ~txShift[BYTE_W-1];
      else if (ctl.txNext)   sdaDriveLow <= ~txShift[BYTE_W-2];
    end
  end

  assign rxByte  = rxShift;
  assign regAddr = regPtr;

endmodule

// File: rtl/smbusByteSlave.sv
module smbusByteSlave
  import smbusSlvPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  output logic [7:0] regAddr,
  output logic [7:0] regWrData,
  output logic       regWrEn,
  output logic       regRdEn,
  input  logic [7:0] regRdData
);

  busEvt_t           busEvt;
  dpCtrl_t           dpCtl;
  logic              sclLevel;
  logic              sdaLevel;
  logic [BYTE_W-1:0] rxByte;
  logic [CNT_W-1:0]  bitCnt;

  smbusLineSync #(.SYNC_STAGES(SYNC_STAGES)) lineSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .evt(busEvt), .sclLevel(sclLevel), .sdaLevel(sdaLevel)
  );

  smbusSlvControl #(.SLAVE_ADDR(SLAVE_ADDR)) control (
    .clk(clk), .rstN(rstN), .evt(busEvt),
    .rxByte(rxByte), .bitCnt(bitCnt), .ctl(dpCtl)
  );

  smbusSlvDatapath datapath (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .sdaBit(sdaLevel),
    .regRdData(regRdData), .rxByte(rxByte), .bitCnt(bitCnt),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/smbusByteSlaveChk.sv
module smbusByteSlaveChk (
  input logic clk,
  input logic rstN,
  input logic sclLevel,
  input logic startSeen,
  input logic sdaDriveLow,
  input logic regWrEn,
  input logic regRdEn
);

  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclLevel);

  // R11
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R11
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaDriveLow);

endmodule

bind smbusByteSlave smbusByteSlaveChk chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel),
  .startSeen(busEvt.startSeen), .sdaDriveLow(sdaDriveLow),
  .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/smbusByteSlave_test.sv
module smbusByteSlave_test;

  localparam logic [6:0] DEV = 7'h3A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow, regWrEn, regRdEn;
  logic [7:0] regAddr, regWrData, regRdData;
  wire sdaLine = sdaM & ~sdaDriveLow;

  smbusByteSlave #(.SLAVE_ADDR(DEV)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData)
  );

  logic [7:0] mem [256];
  int wrCount, rdCount;
  logic [7:0] lastWrAddr, lastWrData, lastRdAddr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      wrCount <= 0; rdCount <= 0; regRdData <= 8'h00;
      lastWrAddr <= 8'h00; lastWrData <= 8'h00; lastRdAddr <= 8'h00;
    end else begin
      if (regWrEn) begin
        mem[regAddr] <= regWrData;
        wrCount <= wrCount + 1;
        lastWrAddr <= regAddr;
        lastWrData <= regWrData;
      end
      if (regRdEn) begin
        regRdData <= mem[regAddr];
        rdCount <= rdCount + 1;
        lastRdAddr <= regAddr;
      end
    end
  end

  int errors = 0;
  int checks = 0;
  int sclHighChanges = 0;
  logic sdaPrevB = 1'b0;

  always @(negedge clk) begin
    if (rstN && (sdaDriveLow !== sdaPrevB) && scl) sclHighChanges++;
    sdaPrevB = sdaDriveLow;
  end

  function automatic logic [7:0] fval(input logic [7:0] a);
    return (a * 8'd29) + 8'd7;
  endfunction

  function automatic logic [7:0] gval(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic writeBit(input logic b, output logic s);
    sdaM = b; waitQ();
    scl = 1'b1; waitQ();
    s = sdaLine; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic startCond();
    if (!scl) begin
      sdaM = 1'b1; waitQ();
      scl = 1'b1; waitQ();
    end
    sdaM = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) writeBit(b[i], s);
    writeBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      writeBit(1'b1, s);
      v[i] = s;
    end
    writeBit(1'b1, s);
  endtask

  task automatic doWrite(input logic [7:0] cmd, input logic [7:0] data, input logic extra,
                         output logic a0, output logic a1, output logic a2, output logic a3);
    startCond();
    sendByte({DEV, 1'b0}, a0);
    // R10: released after the ninth clock
    check(sdaDriveLow == 1'b0, "R10 release", int'(sdaDriveLow), 0);
    sendByte(cmd, a1);
    sendByte(data, a2);
    if (extra) sendByte(8'h77, a3);
    else a3 = 1'b0;
    stopCond();
  endtask

  task automatic doRead(input logic [7:0] cmd, output logic ok, output logic [7:0] v);
    logic a0, a1, a2;
    startCond();
    sendByte({DEV, 1'b0}, a0);
    sendByte(cmd, a1);
    startCond();
    sendByte({DEV, 1'b1}, a2);
    readByte(v);
    stopCond();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    logic a0, a1, a2, a3, ok;
    logic [7:0] v, c, pa;
    int wc, rc;
    repeat (5) @(negedge clk);
    // R1
    check(sdaDriveLow == 0 && regWrEn == 0 && regRdEn == 0 && regAddr == 0, "R1 reset",
          int'({sdaDriveLow, regWrEn, regRdEn, regAddr}), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3, R11: write sweep
    for (int i = 0; i < 16; i++) begin
      c = 8'(i * 17);
      wc = wrCount;
      doWrite(c, fval(c), 1'b0, a0, a1, a2, a3);
      check(a0 && a1 && a2, "R3 acks", int'({a0, a1, a2}), 7);
      check(wrCount == wc + 1 && lastWrAddr == c && lastWrData == fval(c), "R3 write",
            int'(lastWrData), int'(fval(c)));
    end

    // R7: extra byte after data
    wc = wrCount;
    doWrite(8'h40, 8'h99, 1'b1, a0, a1, a2, a3);
    check(!a3, "R7 extra nack", int'(a3), 0);
    check(wrCount == wc + 1 && lastWrData == 8'h99, "R7 single write", wrCount - wc, 1);

    // R6: read sweep
    for (int i = 0; i < 16; i++) begin
      c = 8'(i * 17);
      rc = rdCount;
      doRead(c, ok, v);
      check(ok && v == fval(c), "R6 read byte", int'(v), int'(fval(c)));
      check(rdCount == rc + 1 && lastRdAddr == c, "R6 strobe", int'(lastRdAddr), int'(c));
    end

    // R4: send byte
    wc = wrCount;
    startCond(); sendByte({DEV, 1'b0}, a0); sendByte(8'h35, a1); stopCond();
    check(a0 && a1 && regAddr == 8'h35 && wrCount == wc, "R4 pointer", int'(regAddr), 8'h35);

    // R5: receive byte twice from pointer
    for (int n = 0; n < 2; n++) begin
      rc = rdCount;
      startCond(); sendByte({DEV, 1'b1}, a0); readByte(v); stopCond();
      check(a0 && v == gval(8'h35), "R5 receive", int'(v), int'(gval(8'h35)));
      check(rdCount == rc + 1 && lastRdAddr == 8'h35, "R5 strobe", rdCount - rc, 1);
    end
    startCond(); sendByte({DEV, 1'b0}, a0); sendByte(8'h11, a1); stopCond();
    startCond(); sendByte({DEV, 1'b1}, a0); readByte(v); stopCond();
    check(v == fval(8'h11), "R5 receive written", int'(v), int'(fval(8'h11)));

    // R2: non-matching address sweep
    for (int k = 1; k < 128; k += 9) begin
      wc = wrCount; rc = rdCount; pa = regAddr;
      startCond();
      sendByte({7'(k), 1'(k & 1)}, a0);
      sendByte(8'h55, a1);
      sendByte(8'hAA, a2);
      stopCond();
      check(!a0 && !a1 && !a2, "R2 nack", int'({a0, a1, a2}), 0);
      check(wrCount == wc && rdCount == rc && regAddr == pa, "R2 no access",
            int'(regAddr), int'(pa));
    end

    // R8: STOP inside data byte
    wc = wrCount;
    startCond(); sendByte({DEV, 1'b0}, a0); sendByte(8'h81, a1);
    for (int i = 0; i < 4; i++) writeBit(1'b1, a2);
    stopCond();
    check(wrCount == wc, "R8 stop abandon", wrCount - wc, 0);
    // R8: repeated START inside data byte, then a full write
    startCond(); sendByte({DEV, 1'b0}, a0); sendByte(8'h82, a1);
    for (int i = 0; i < 3; i++) writeBit(1'b0, a2);
    startCond();
    sendByte({DEV, 1'b0}, a0); sendByte(8'h83, a1); sendByte(8'h5C, a2); stopCond();
    check(a0 && a1 && a2 && wrCount == wc + 1 && lastWrAddr == 8'h83 && lastWrData == 8'h5C,
          "R8 restart write", int'(lastWrAddr), 8'h83);
    doRead(8'h81, ok, v);
    check(ok && v == gval(8'h81), "R8 untouched 81", int'(v), int'(gval(8'h81)));
    doRead(8'h82, ok, v);
    check(ok && v == gval(8'h82), "R8 untouched 82", int'(v), int'(gval(8'h82)));

    // R9
    check(sclHighChanges == 0, "R9 sda while scl high", sclHighChanges, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule